// File: doc/BRIEF.md
# Event Entry and Vectoring Controller

This block decides, once per clock, which pending processor event the core enters next, and performs the bookkeeping of that entry. Five sources compete: a synchronous reset request, a software user-vector trap, an external interrupt, a break and a hardware exception. The winner is chosen by a fixed priority, filtered by the current enable and in-progress bits. For the winner the block asks the register file to write the return address into that event's link register, and asks the fetch stage to load that event's fixed vector into the program counter.

It also keeps the machine-status bits that govern entry: interrupt enable, exception enable, break in progress and exception in progress. For exceptions it keeps the cause code, the faulting address and a flag for an exception taken in a branch delay slot. In that delay-slot case the branch target is saved in a dedicated register, because the exception link register cannot hold a useful return address. Three return strobes undo the status changes when a handler finishes.

All outputs are registered. An accepted request at a rising edge appears on the outputs in the following cycle.

Top module: `evt_vector_unit`

## Requirements
- R1: With `rst_n` low, or one cycle after `rst_req` is seen at an edge, the status is IE=1, EE=1, BIP=0, EIP=0, and cause, delay-slot flag, EAR and BTR are all zero. `rst_n` low gives `pc_load`=0, `lr_we`=0 and `evt_kind`=7. A `rst_req` gives `pc_load`=1, `pc_next`=0x00000000, `evt_kind`=0 and `lr_we`=0.
- R2: The accepted event is chosen by this priority: reset request, then exception, then break, then interrupt, then user vector. `evt_kind` reports it as 0=reset, 1=user vector, 2=interrupt, 3=break, 4=exception.
- R3: A user-vector event loads `pc_next`=0x00000008. It writes `cur_pc` into the register numbered by `uvec_reg`. It changes no status bit.
- R4: An interrupt loads `pc_next`=0x00000010, writes `cur_pc` into register 14 and clears IE.
- R5: An interrupt request is accepted only while IE=1, BIP=0 and EIP=0. Otherwise it produces no load and changes no state.
- R6: A break loads `pc_next`=0x00000018, writes `cur_pc` into register 16 and sets BIP. A break request is ignored while BIP=1.
- R7: An exception loads `pc_next`=0x00000020, clears EE, sets EIP, stores `exc_cause` and stores `exc_addr` into EAR. An exception request is ignored while EE=0.
- R8: An exception with `exc_in_dslot`=0 writes `cur_pc`+4 into register 17, clears the delay-slot flag and leaves BTR unchanged.
- R9: An exception with `exc_in_dslot`=1 sets the delay-slot flag, loads BTR from `br_target`, and makes no link-register write (`lr_we`=0).
- R10: `ret_irq` sets IE, `ret_brk` clears BIP, and `ret_exc` sets EE and clears EIP. All three are ignored in any cycle in which an event is accepted.
- R11: `pc_load` is high for exactly the one cycle after an accepted event. It is low after any cycle with no accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Synchronous reset event request |
| uvec_req | input | 1 | User-vector trap request |
| uvec_reg | input | RIDX_W | Link register chosen by the trap |
| irq_req | input | 1 | External interrupt request |
| brk_req | input | 1 | Break request |
| exc_req | input | 1 | Hardware exception request |
| exc_in_dslot | input | 1 | Exception instruction sits in a delay slot |
| exc_cause | input | CAUSE_W | Exception cause code |
| exc_addr | input | XLEN | Address associated with the exception |
| br_target | input | XLEN | Target of the branch owning the delay slot |
| cur_pc | input | XLEN | PC of the instruction at which the event is taken |
| ret_irq | input | 1 | Return from interrupt |
| ret_brk | input | 1 | Return from break |
| ret_exc | input | 1 | Return from exception |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | XLEN | Event vector address |
| evt_kind | output | 3 | Accepted event code (7 = none) |
| lr_we | output | 1 | Link register write enable |
| lr_idx | output | RIDX_W | Link register number |
| lr_data | output | XLEN | Return address to store |
| msr_ie | output | 1 | Interrupt enable |
| msr_ee | output | 1 | Exception enable |
| msr_bip | output | 1 | Break in progress |
| msr_eip | output | 1 | Exception in progress |
| esr_cause | output | CAUSE_W | Saved exception cause |
| esr_ds | output | 1 | Exception was in a delay slot |
| ear | output | XLEN | Saved exception address |
| btr | output | XLEN | Saved branch target |

## Verification
The bench uses the default parameters: 32-bit addresses, 5-bit register numbers and cause codes, and link registers 14, 16 and 17. It sweeps all 32 combinations of the five request inputs from three starting states: fresh, inside an exception, and inside a break. Each combination is run with the return strobes both off and on. This reaches every priority pairing, every gating condition and every collision between an event and a return. Directed sequences then cover interrupt blocking under each cause, both delay-slot cases, and the idle cycle after each entry.

// File: rtl/evu_pkg.sv
package evu_pkg;

  // Event codes; the vector address is the code shifted left by three.
  typedef enum logic [2:0] {
    EV_RST  = 3'd0,
    EV_UVEC = 3'd1,
    EV_IRQ  = 3'd2,
    EV_BRK  = 3'd3,
    EV_EXC  = 3'd4,
    EV_NONE = 3'd7
  } evt_e;

  localparam int unsigned NUM_EVT = 5;

  // Low bits of the vector address for an event.
  function automatic logic [5:0] vec_low(evt_e k);
    return {k, 3'b000};
  endfunction

endpackage

// File: rtl/evu_arb.sv
module evu_arb
  import evu_pkg::*;
(
  input  logic                 req_rst,
  input  logic                 req_exc,
  input  logic                 req_brk,
  input  logic                 req_irq,
  input  logic                 req_uvec,
  input  logic                 ie,
  input  logic                 ee,
  input  logic                 bip,
  input  logic                 eip,
  output logic [NUM_EVT-1:0]   grant,
  output evt_e                 kind
);

  logic [NUM_EVT-1:0] elig;

  // Eligibility, indexed by event code.
  always_comb begin
    elig          = '0;
    elig[EV_RST]  = req_rst;
    elig[EV_UVEC] = req_uvec;
    elig[EV_IRQ]  = req_irq & ie & ~bip & ~eip;
    elig[EV_BRK]  = req_brk & ~bip;
    elig[EV_EXC]  = req_exc & ee;
  end

  // The highest non-reset code wins; reset then overrides everything.
  always_comb begin
    kind = EV_NONE;
    for (int i = 1; i < NUM_EVT; i++) begin
      if (elig[i]) kind = evt_e'(3'(i));
    end
    if (elig[EV_RST]) kind = EV_RST;
  end

  generate
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_grant
      assign grant[g] = (kind == evt_e'(3'(g)));
    end
  endgenerate

  always_comb begin
    AST_RST_WINS: assert (!req_rst || kind == EV_RST); // R2
  end

endmodule

// File: rtl/evu_status.sv
module evu_status
  import evu_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5,
  parameter bit          IE_INIT = 1'b1,
  parameter bit          EE_INIT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  evt_e               kind,
  input  logic               exc_ds,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    exc_addr,
  input  logic [XLEN-1:0]    br_target,
  input  logic               ret_irq,
  input  logic               ret_brk,
  input  logic               ret_exc,
  output logic               ie,
  output logic               ee,
  output logic               bip,
  output logic               eip,
  output logic [CAUSE_W-1:0] esr_cause,
  output logic               esr_ds,
  output logic [XLEN-1:0]    ear,
  output logic [XLEN-1:0]    btr
);

  logic do_reset;
  logic idle;
  assign do_reset = take && (kind == EV_RST);
  assign idle     = !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie        <= IE_INIT;
      ee        <= EE_INIT;
      bip       <= 1'b0;
      eip       <= 1'b0;
      esr_cause <= '0;
      esr_ds    <= 1'b0;
      ear       <= '0;
      btr       <= '0;
    end else if (do_reset) begin
      ie        <= IE_INIT;
      ee        <= EE_INIT;
      bip       <= 1'b0;
      eip       <= 1'b0;
      esr_cause <= '0;
      esr_ds    <= 1'b0;
      ear       <= '0;
      btr       <= '0;
    end else if (take) begin
      case (kind)
        EV_IRQ: ie <= 1'b0;
        EV_BRK: bip <= 1'b1;
        EV_EXC: begin
          ee        <= 1'b0;
          eip       <= 1'b1;
          esr_cause <= cause;
          ear       <= exc_addr;
          esr_ds    <= exc_ds;
          if (exc_ds) btr <= br_target;
        end
        default: ;
      endcase
    end else begin
      if (ret_irq) ie <= 1'b1;
      if (ret_brk) bip <= 1'b0;
      if (ret_exc) begin
        ee  <= 1'b1;
        eip <= 1'b0;
      end
    end
  end

  AST_IRQ_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == EV_IRQ) |=> !ie); // R4
  AST_BRK_SETS_BIP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == EV_BRK) |=> bip); // R6
  AST_EXC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == EV_EXC) |=> (eip && !ee)); // R7
  AST_DS_BTR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == EV_EXC && exc_ds) |=> (esr_ds && btr == $past(br_target))); // R9
  AST_RET_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && ret_exc) |=> (ee && !eip)); // R10

endmodule

// File: rtl/evu_entry.sv
module evu_entry
  import evu_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned RIDX_W  = 5,
  parameter int unsigned IRQ_LR  = 14,
  parameter int unsigned BRK_LR  = 16,
  parameter int unsigned EXC_LR  = 17,
  parameter int unsigned PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evt_e              kind,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [RIDX_W-1:0] uvec_reg,
  input  logic              exc_ds,
  output logic              pc_load,
  output logic [XLEN-1:0]   pc_next,
  output logic [2:0]        evt_kind,
  output logic              lr_we,
  output logic [RIDX_W-1:0] lr_idx,
  output logic [XLEN-1:0]   lr_data
);

  function automatic logic [RIDX_W-1:0] link_index(evt_e k, logic [RIDX_W-1:0] chosen);
    case (k)
      EV_IRQ:  return RIDX_W'(IRQ_LR);
      EV_BRK:  return RIDX_W'(BRK_LR);
      EV_EXC:  return RIDX_W'(EXC_LR);
      default: return chosen;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] link_value(evt_e k, logic [XLEN-1:0] pc);
    return (k == EV_EXC) ? pc + XLEN'(PC_STEP) : pc;
  endfunction

  function automatic logic link_write(evt_e k, logic ds);
    case (k)
      EV_UVEC, EV_IRQ, EV_BRK: return 1'b1;
      EV_EXC:                  return !ds;
      default:                 return 1'b0;
    endcase
  endfunction

  logic take;
  assign take = (kind != EV_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load  <= 1'b0;
      pc_next  <= '0;
      evt_kind <= EV_NONE;
      lr_we    <= 1'b0;
      lr_idx   <= '0;
      lr_data  <= '0;
    end else begin
      pc_load  <= take;
      evt_kind <= kind;
      lr_we    <= link_write(kind, exc_ds);
      if (take) begin
        pc_next <= XLEN'(vec_low(kind));
        lr_idx  <= link_index(kind, uvec_reg);
        lr_data <= link_value(kind, cur_pc);
      end
    end
  end

  AST_LINK_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> pc_load); // R11
  AST_DS_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EV_EXC && exc_ds) |=> !lr_we); // R9
  AST_EXC_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EV_EXC && !exc_ds) |=> (lr_data == $past(cur_pc) + XLEN'(PC_STEP))); // R8

endmodule

// File: rtl/evt_vector_unit.sv
module evt_vector_unit
  import evu_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned RIDX_W  = 5,
  parameter int unsigned CAUSE_W = 5,
  parameter int unsigned IRQ_LR  = 14,
  parameter int unsigned BRK_LR  = 16,
  parameter int unsigned EXC_LR  = 17,
  parameter int unsigned PC_STEP = 4,
  parameter bit          IE_INIT = 1'b1,
  parameter bit          EE_INIT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_req,
  input  logic               uvec_req,
  input  logic [RIDX_W-1:0]  uvec_reg,
  input  logic               irq_req,
  input  logic               brk_req,
  input  logic               exc_req,
  input  logic               exc_in_dslot,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic [XLEN-1:0]    exc_addr,
  input  logic [XLEN-1:0]    br_target,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               ret_irq,
  input  logic               ret_brk,
  input  logic               ret_exc,
  output logic               pc_load,
  output logic [XLEN-1:0]    pc_next,
  output logic [2:0]         evt_kind,
  output logic               lr_we,
  output logic [RIDX_W-1:0]  lr_idx,
  output logic [XLEN-1:0]    lr_data,
  output logic               msr_ie,
  output logic               msr_ee,
  output logic               msr_bip,
  output logic               msr_eip,
  output logic [CAUSE_W-1:0] esr_cause,
  output logic               esr_ds,
  output logic [XLEN-1:0]    ear,
  output logic [XLEN-1:0]    btr
);

  logic [NUM_EVT-1:0] grant;
  evt_e               win_kind;
  logic               evt_take;

  evu_arb u_arb (
    .req_rst (rst_req),
    .req_exc (exc_req),
    .req_brk (brk_req),
    .req_irq (irq_req),
    .req_uvec(uvec_req),
    .ie      (msr_ie),
    .ee      (msr_ee),
    .bip     (msr_bip),
    .eip     (msr_eip),
    .grant   (grant),
    .kind    (win_kind)
  );

  assign evt_take = |grant;

  evu_status #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .IE_INIT(IE_INIT), .EE_INIT(EE_INIT)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (evt_take),
    .kind     (win_kind),
    .exc_ds   (exc_in_dslot),
    .cause    (exc_cause),
    .exc_addr (exc_addr),
    .br_target(br_target),
    .ret_irq  (ret_irq),
    .ret_brk  (ret_brk),
    .ret_exc  (ret_exc),
    .ie       (msr_ie),
    .ee       (msr_ee),
    .bip      (msr_bip),
    .eip      (msr_eip),
    .esr_cause(esr_cause),
    .esr_ds   (esr_ds),
    .ear      (ear),
    .btr      (btr)
  );

  evu_entry #(
    .XLEN(XLEN), .RIDX_W(RIDX_W), .IRQ_LR(IRQ_LR), .BRK_LR(BRK_LR),
    .EXC_LR(EXC_LR), .PC_STEP(PC_STEP)
  ) u_entry (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (win_kind),
    .cur_pc  (cur_pc),
    .uvec_reg(uvec_reg),
    .exc_ds  (exc_in_dslot),
    .pc_load (pc_load),
    .pc_next (pc_next),
    .evt_kind(evt_kind),
    .lr_we   (lr_we),
    .lr_idx  (lr_idx),
    .lr_data (lr_data)
  );

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && evt_kind == 3'(EV_IRQ)) |-> $past(msr_ie && !msr_bip && !msr_eip)); // R5
  AST_NO_REQ_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req || uvec_req || irq_req || brk_req || exc_req) |=> !pc_load); // R11
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

endmodule

// File: tb/evt_vector_unit_tb.sv
module evt_vector_unit_tb;

  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_req = 0, uvec_req = 0, irq_req = 0, brk_req = 0, exc_req = 0;
  logic        exc_in_dslot = 0, ret_irq = 0, ret_brk = 0, ret_exc = 0;
  logic [4:0]  uvec_reg = '0, exc_cause = '0;
  logic [31:0] exc_addr = '0, br_target = '0, cur_pc = '0;
  logic        pc_load, lr_we, msr_ie, msr_ee, msr_bip, msr_eip, esr_ds;
  logic [31:0] pc_next, lr_data, ear, btr;
  logic [2:0]  evt_kind;
  logic [4:0]  lr_idx, esr_cause;

  int n_chk = 0;
  int n_err = 0;

  // Reference state
  logic        m_ie, m_ee, m_bip, m_eip, m_ds;
  logic [4:0]  m_cause;
  logic [31:0] m_ear, m_btr;

  always #(CLK_P/2) clk = ~clk;

  evt_vector_unit u_dut (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .uvec_req(uvec_req),
    .uvec_reg(uvec_reg), .irq_req(irq_req), .brk_req(brk_req),
    .exc_req(exc_req), .exc_in_dslot(exc_in_dslot), .exc_cause(exc_cause),
    .exc_addr(exc_addr), .br_target(br_target), .cur_pc(cur_pc),
    .ret_irq(ret_irq), .ret_brk(ret_brk), .ret_exc(ret_exc),
    .pc_load(pc_load), .pc_next(pc_next), .evt_kind(evt_kind),
    .lr_we(lr_we), .lr_idx(lr_idx), .lr_data(lr_data),
    .msr_ie(msr_ie), .msr_ee(msr_ee), .msr_bip(msr_bip), .msr_eip(msr_eip),
    .esr_cause(esr_cause), .esr_ds(esr_ds), .ear(ear), .btr(btr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ie = 1'b1; m_ee = 1'b1; m_bip = 1'b0; m_eip = 1'b0;
    m_ds = 1'b0; m_cause = '0; m_ear = '0; m_btr = '0;
  endtask

  task automatic chk_status(string tag);
    chk({tag, " ie"},    32'(msr_ie),    32'(m_ie));
    chk({tag, " ee"},    32'(msr_ee),    32'(m_ee));
    chk({tag, " bip"},   32'(msr_bip),   32'(m_bip));
    chk({tag, " eip"},   32'(msr_eip),   32'(m_eip));
    chk({tag, " cause"}, 32'(esr_cause), 32'(m_cause));
    chk({tag, " ds"},    32'(esr_ds),    32'(m_ds));
    chk({tag, " ear"},   ear,            m_ear);
    chk({tag, " btr"},   btr,            m_btr);
  endtask

  // One request cycle: drive at a falling edge, sample at the next falling edge.
  task automatic step(string ltag, bit r, bit e, bit b, bit i, bit u, bit ds, bit rt,
                      logic [31:0] pc);
    int w;
    logic [31:0] vec, ldat;
    logic [4:0] lidx;
    logic lwe;
    string stag;
    rst_req = r; exc_req = e; brk_req = b; irq_req = i; uvec_req = u;
    exc_in_dslot = ds; ret_irq = rt; ret_brk = rt; ret_exc = rt;
    cur_pc = pc; uvec_reg = pc[8:4]; exc_cause = pc[8:4] ^ 5'h0a;
    exc_addr = pc ^ 32'hA5A5_0000; br_target = pc + 32'h100;
    // Winner per R2 with the gating of R5, R6 and R7
    if (r) w = 0;
    else if (e && m_ee) w = 4;
    else if (b && !m_bip) w = 3;
    else if (i && m_ie && !m_bip && !m_eip) w = 2;
    else if (u) w = 1;
    else w = 7;
    vec = 32'(w) * 32'd8;
    ldat = pc; lidx = uvec_reg; lwe = 1'b1;
    case (w)
      0: begin stag = "R1"; lwe = 1'b0; end
      1: stag = "R3";
      2: begin stag = "R4"; lidx = 5'd14; end
      3: begin stag = "R6"; lidx = 5'd16; end
      4: begin
        lidx = 5'd17; ldat = pc + 32'd4;
        if (ds) begin stag = "R9"; lwe = 1'b0; end else stag = "R8";
      end
      default: begin stag = "R10"; lwe = 1'b0; end
    endcase
    @(posedge clk);
    @(negedge clk);
    // Model update
    case (w)
      0: model_reset();
      2: m_ie = 1'b0;
      3: m_bip = 1'b1;
      4: begin
        m_ee = 1'b0; m_eip = 1'b1; m_cause = exc_cause; m_ear = exc_addr; m_ds = ds;
        if (ds) m_btr = br_target;
      end
      7: if (rt) begin m_ie = 1'b1; m_bip = 1'b0; m_ee = 1'b1; m_eip = 1'b0; end
      default: ;
    endcase
    chk({ltag, " pc_load"}, 32'(pc_load), 32'(w != 7));
    chk("R2 evt_kind", 32'(evt_kind), 32'(w));
    chk({stag, " lr_we"}, 32'(lr_we), 32'(lwe));
    if (w != 7) chk({stag, " pc_next"}, pc_next, vec);
    if (lwe) begin
      chk({stag, " lr_idx"}, 32'(lr_idx), 32'(lidx));
      chk({stag, " lr_data"}, lr_data, ldat);
    end
    chk_status(stag);
    rst_req = 0; exc_req = 0; brk_req = 0; irq_req = 0; uvec_req = 0;
    exc_in_dslot = 0; ret_irq = 0; ret_brk = 0; ret_exc = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: asynchronous reset state
    chk("R1 pc_load", 32'(pc_load), 32'd0);
    chk("R1 evt_kind", 32'(evt_kind), 32'd7);
    chk("R1 lr_we", 32'(lr_we), 32'd0);
    chk_status("R1");
    rst_n = 1'b1;
    @(negedge clk);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 32'h0000_4000);

    // Sweep: three starting states, all request masks, returns off/on (R2)
    for (int st = 0; st < 3; st++) begin
      for (int m = 0; m < 32; m++) begin
        for (int rt = 0; rt < 2; rt++) begin
          logic [31:0] pc;
          pc = 32'h0001_0000 + 32'(m) * 32'h40 + 32'(rt) * 32'h10 + 32'(st) * 32'h1000;
          step("R1", 1, 0, 0, 0, 0, 0, 0, 32'h0);
          if (st == 1) step("R7", 0, 1, 0, 0, 0, 0, 0, pc ^ 32'h0F00);
          if (st == 2) step("R6", 0, 0, 1, 0, 0, 0, 0, pc ^ 32'h0F00);
          step("R2", m[4], m[3], m[2], m[1], m[0], m[2] ^ m[0], rt[0], pc);
          step("R11", 0, 0, 0, 0, 0, 0, 0, pc + 32'h8);
        end
      end
    end

    // R5: interrupt gating by IE, BIP and EIP
    step("R1", 1, 0, 0, 0, 0, 0, 0, 32'h0);
    step("R4", 0, 0, 0, 1, 0, 0, 0, 32'h0002_0000);
    step("R5", 0, 0, 0, 1, 0, 0, 0, 32'h0002_0004);
    step("R10", 0, 0, 0, 0, 0, 0, 1, 32'h0002_0008);
    step("R6", 0, 0, 1, 0, 0, 0, 0, 32'h0002_000C);
    step("R5", 0, 0, 0, 1, 0, 0, 0, 32'h0002_0010);
    step("R6", 0, 0, 1, 0, 0, 0, 0, 32'h0002_0014);
    step("R10", 0, 0, 0, 0, 0, 0, 1, 32'h0002_0018);
    step("R9", 0, 1, 0, 0, 0, 1, 0, 32'h0002_001C);
    step("R5", 0, 0, 0, 1, 0, 0, 0, 32'h0002_0020);
    step("R7", 0, 1, 0, 0, 0, 0, 0, 32'h0002_0024);
    step("R10", 0, 0, 0, 0, 0, 0, 1, 32'h0002_0028);
    step("R8", 0, 1, 0, 0, 0, 0, 0, 32'h0002_002C);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 32'h0002_0030);
    step("R10", 0, 0, 0, 0, 0, 0, 1, 32'h0002_0034);
    step("R3", 0, 0, 0, 0, 1, 0, 0, 32'h0002_0FF0);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 32'h0002_0FF4);

    finish_run();
  end

endmodule